// File: doc/BRIEF.md
# Switch-on-miss thread scheduler

This block chooses which hardware thread context supplies instructions to a short in-order pipeline. One thread owns the fetch slot and issues one instruction on every cycle. When its oldest in-flight instruction reports a miss in the local cache, the thread is parked and control passes to another thread. All of the parked thread's instructions still in the pipeline are squashed, and its program counter is wound back to the instruction that missed. Each thread keeps its own registers, so a switch saves and restores no architectural state. The only cost of a switch is the squashed work, which a counter accumulates.

A parked thread becomes eligible again only when a miss-return tagged with its thread number arrives. The successor is chosen round-robin among ready threads, beginning with the thread after the one that was parked. The controller has two states. `ST_RUN` issues from the current thread. `ST_IDLE` sends bubbles because no thread is ready. Its three transitions are:

- switch: `ST_RUN` to `ST_RUN` with a new thread, on a miss while another thread is ready.
- starve: `ST_RUN` to `ST_IDLE`, on a miss when no other thread is ready.
- wake: `ST_IDLE` to `ST_RUN`, on the edge that ends the cycle in which a return arrives.

The scheduler keeps its own shadow of the pipeline stages, one entry per stage holding a valid bit, the thread and the PC. From this shadow it forms the squash mask.

Top module: `miss_switch_sched`

## Requirements
- R1: After synchronous active-low reset, all threads are ready, thread 0 is issuing at its start PC (thread t starts at t*PC_STRIDE, default stride 0x100), and both counters read zero.
- R2: While no miss is accepted, the current thread issues on every cycle, and its PC rises by one per issued instruction.
- R3: A miss is accepted only if the oldest shadow stage (index PIPE_DEPTH-1) holds a valid instruction whose thread equals the miss tag. Any other miss is ignored: fetch continues unchanged and the squash mask stays zero.
- R4: In the cycle of an accepted miss, `squash_mask` bit i is set for every stage i holding an instruction of the missing thread. Bit 0 is the youngest stage and bit PIPE_DEPTH-1 the oldest. Fetch is suppressed in that same cycle.
- R5: The parked thread's PC is reloaded with the PC of the instruction that missed, so it resumes there.
- R6: On an accepted miss, the next thread is the first ready thread found by counting upward from the parked thread plus one, wrapping at NUM_THREADS. It issues from the next cycle.
- R7: With no ready thread the block is in `ST_IDLE`. `fetch_valid` is 0 there, and `idle_total` grows by one for each idle cycle.
- R8: A return tagged with a parked thread makes that thread ready. In `ST_IDLE` the edge ending the return cycle resumes issue, picking round-robin after the last parked thread. A return for a thread that is already ready has no effect.
- R9: `cost_total` grows by the number of squashed instructions on each accepted miss and is otherwise unchanged.
- R10: A parked thread never issues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| miss_valid | input | 1 | Cache miss reported by the pipeline this cycle |
| miss_tid | input | TID_W | Thread tag of the miss |
| ret_valid | input | 1 | Miss data returned this cycle |
| ret_tid | input | TID_W | Thread tag of the return |
| fetch_valid | output | 1 | Fetch slot used this cycle |
| fetch_tid | output | TID_W | Thread being fetched |
| fetch_pc | output | PC_W | PC being fetched |
| squash_mask | output | PIPE_DEPTH | Stages to kill this cycle, bit 0 youngest |
| cost_total | output | CNT_W | Accumulated squashed instructions |
| idle_total | output | CNT_W | Accumulated idle cycles |

## Verification
A corrupt shadow stage shows up as a wrong squash mask, or as a wrongly accepted or rejected miss, in the very cycle the miss is presented. It also reaches the PC port one cycle later, when the parked thread's rewound PC is fetched. A wrong ready bit appears at the first switch after it: the successor thread is wrong, a parked thread issues, or the block idles although a thread is ready. Because the PC rewind is checked when the thread resumes, a PC-bank fault can surface tens of cycles after it was made.

// File: rtl/mss_pkg.sv
package mss_pkg;

    typedef enum logic [0:0] {
        ST_RUN  = 1'b0,
        ST_IDLE = 1'b1
    } sched_state_e;

endpackage

// File: rtl/mss_rr_pick.sv
module mss_rr_pick #(
    parameter int N     = 4,
    parameter int TID_W = 2
) (
    input  logic [N-1:0]     ready,
    input  logic [TID_W-1:0] after,
    output logic             found,
    output logic [TID_W-1:0] pick
);

    always_comb begin
        logic [TID_W:0] pos;
        found = 1'b0;
        pick  = after;
        for (int j = 1; j <= N; j++) begin
            pos = {1'b0, after} + (TID_W+1)'(j);
            if (pos >= (TID_W+1)'(N)) begin
                pos = pos - (TID_W+1)'(N);
            end
            if (!found && ready[pos[TID_W-1:0]]) begin
                found = 1'b1;
                pick  = pos[TID_W-1:0];
            end
        end
    end

endmodule

// File: rtl/mss_stage_track.sv
module mss_stage_track #(
    parameter int DEPTH = 5,
    parameter int TID_W = 2,
    parameter int PC_W  = 16,
    parameter int SQ_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_en,
    input  logic [TID_W-1:0] issue_tid,
    input  logic [PC_W-1:0]  issue_pc,
    input  logic             miss_valid,
    input  logic [TID_W-1:0] miss_tid,
    output logic             miss_take,
    output logic [PC_W-1:0]  oldest_pc,
    output logic [DEPTH-1:0] squash_mask,
    output logic [SQ_W-1:0]  squash_cnt
);

    logic [DEPTH-1:0] vld_q;
    logic [TID_W-1:0] tid_q [DEPTH];
    logic [PC_W-1:0]  pc_q  [DEPTH];

    assign miss_take = miss_valid && vld_q[DEPTH-1] && (tid_q[DEPTH-1] == miss_tid);
    assign oldest_pc = pc_q[DEPTH-1];

    for (genvar i = 0; i < DEPTH; i++) begin : g_sq
        assign squash_mask[i] = miss_take && vld_q[i] && (tid_q[i] == miss_tid);
    end

    always_comb begin
        squash_cnt = '0;
        for (int i = 0; i < DEPTH; i++) begin
            squash_cnt = squash_cnt + SQ_W'(squash_mask[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                tid_q[i] <= '0;
                pc_q[i]  <= '0;
            end
        end else begin
            vld_q[0] <= issue_en;
            tid_q[0] <= issue_tid;
            pc_q[0]  <= issue_pc;
            for (int i = 1; i < DEPTH; i++) begin
                vld_q[i] <= vld_q[i-1] && !squash_mask[i-1];
                tid_q[i] <= tid_q[i-1];
                pc_q[i]  <= pc_q[i-1];
            end
        end
    end

    // after a squash the oldest stage no longer carries the missing thread
    AST_SQUASH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        miss_take |=> !(vld_q[DEPTH-1] && (tid_q[DEPTH-1] == $past(miss_tid)))); // R4

    AST_MISS_NEEDS_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
        miss_take |-> squash_mask[DEPTH-1]); // R3

endmodule

// File: rtl/mss_pc_bank.sv
module mss_pc_bank #(
    parameter int N         = 4,
    parameter int TID_W     = 2,
    parameter int PC_W      = 16,
    parameter int PC_STRIDE = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_en,
    input  logic [TID_W-1:0] issue_tid,
    input  logic             rewind_en,
    input  logic [TID_W-1:0] rewind_tid,
    input  logic [PC_W-1:0]  rewind_pc,
    input  logic [TID_W-1:0] rd_tid,
    output logic [PC_W-1:0]  rd_pc
);

    logic [PC_W-1:0] pc_q [N];

    assign rd_pc = pc_q[rd_tid];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int t = 0; t < N; t++) begin
                pc_q[t] <= PC_W'(t * PC_STRIDE);
            end
        end else begin
            for (int t = 0; t < N; t++) begin
                if (rewind_en && (rewind_tid == TID_W'(t))) begin
                    pc_q[t] <= rewind_pc;
                end else if (issue_en && (issue_tid == TID_W'(t))) begin
                    pc_q[t] <= pc_q[t] + PC_W'(1);
                end
            end
        end
    end

    AST_PC_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_en && !rewind_en) |=> (pc_q[$past(issue_tid)] == $past(rd_pc) + PC_W'(1))); // R2

endmodule

// File: rtl/miss_switch_sched.sv
module miss_switch_sched #(
    parameter int NUM_THREADS = 4,
    parameter int PIPE_DEPTH  = 5,
    parameter int PC_W        = 16,
    parameter int PC_STRIDE   = 256,
    parameter int CNT_W       = 16,
    localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
    localparam int SQ_W       = $clog2(PIPE_DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  miss_valid,
    input  logic [TID_W-1:0]      miss_tid,
    input  logic                  ret_valid,
    input  logic [TID_W-1:0]      ret_tid,
    output logic                  fetch_valid,
    output logic [TID_W-1:0]      fetch_tid,
    output logic [PC_W-1:0]       fetch_pc,
    output logic [PIPE_DEPTH-1:0] squash_mask,
    output logic [CNT_W-1:0]      cost_total,
    output logic [CNT_W-1:0]      idle_total
);

    import mss_pkg::*;

    localparam logic [NUM_THREADS-1:0] ONE_HOT0 = NUM_THREADS'(1);

    sched_state_e            state_q, state_d;
    logic [TID_W-1:0]        cur_q, cur_d;
    logic [NUM_THREADS-1:0]  ready_q, ready_next;
    logic [NUM_THREADS-1:0]  miss_mask, ret_mask;
    logic [CNT_W-1:0]        cost_q, idle_q;

    logic                    miss_take;
    logic [PC_W-1:0]         oldest_pc;
    logic [SQ_W-1:0]         squash_cnt;
    logic [PC_W-1:0]         cur_pc;
    logic                    pick_found;
    logic [TID_W-1:0]        pick_tid;
    logic [TID_W-1:0]        pick_after;

    mss_stage_track #(
        .DEPTH (PIPE_DEPTH),
        .TID_W (TID_W),
        .PC_W  (PC_W),
        .SQ_W  (SQ_W)
    ) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .issue_en    (fetch_valid),
        .issue_tid   (cur_q),
        .issue_pc    (cur_pc),
        .miss_valid  (miss_valid),
        .miss_tid    (miss_tid),
        .miss_take   (miss_take),
        .oldest_pc   (oldest_pc),
        .squash_mask (squash_mask),
        .squash_cnt  (squash_cnt)
    );

    mss_pc_bank #(
        .N         (NUM_THREADS),
        .TID_W     (TID_W),
        .PC_W      (PC_W),
        .PC_STRIDE (PC_STRIDE)
    ) u_pcs (
        .clk        (clk),
        .rst_n      (rst_n),
        .issue_en   (fetch_valid),
        .issue_tid  (cur_q),
        .rewind_en  (miss_take),
        .rewind_tid (miss_tid),
        .rewind_pc  (oldest_pc),
        .rd_tid     (cur_q),
        .rd_pc      (cur_pc)
    );

    assign miss_mask  = miss_take ? (ONE_HOT0 << miss_tid) : '0;
    assign ret_mask   = ret_valid ? (ONE_HOT0 << ret_tid) : '0;
    assign ready_next = (ready_q | ret_mask) & ~miss_mask;
    assign pick_after = miss_take ? miss_tid : cur_q;

    mss_rr_pick #(
        .N     (NUM_THREADS),
        .TID_W (TID_W)
    ) u_pick (
        .ready (ready_next),
        .after (pick_after),
        .found (pick_found),
        .pick  (pick_tid)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            cur_q   <= '0;
            ready_q <= '1;
            cost_q  <= '0;
            idle_q  <= '0;
        end else begin
            state_q <= state_d;
            cur_q   <= cur_d;
            ready_q <= ready_next;
            if (miss_take) begin
                cost_q <= cost_q + CNT_W'(squash_cnt);
            end
            if (state_q == ST_IDLE) begin
                idle_q <= idle_q + CNT_W'(1);
            end
        end
    end

    // next state and outputs
    always_comb begin
        state_d     = state_q;
        cur_d       = cur_q;
        fetch_valid = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                fetch_valid = !(miss_take && (miss_tid == cur_q));
                if (miss_take) begin
                    if (pick_found) begin
                        cur_d = pick_tid;
                    end else begin
                        state_d = ST_IDLE;
                        cur_d   = miss_tid;
                    end
                end
            end
            ST_IDLE: begin
                if (pick_found) begin
                    state_d = ST_RUN;
                    cur_d   = pick_tid;
                end
            end
            default: begin
                state_d = ST_RUN;
            end
        endcase
    end

    assign fetch_tid  = cur_q;
    assign fetch_pc   = cur_pc;
    assign cost_total = cost_q;
    assign idle_total = idle_q;

    AST_PARKED_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid |-> ready_q[fetch_tid]); // R10

    AST_SWITCH_AWAY: assert property (@(posedge clk) disable iff (!rst_n)
        miss_take |=> (!fetch_valid || (fetch_tid != $past(miss_tid)))); // R6

    AST_IDLE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> (idle_total == $past(idle_total) + CNT_W'(1))); // R7

    AST_COST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !miss_take |=> $stable(cost_total)); // R9

    AST_WAKE_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_IDLE) && ret_valid) |=> fetch_valid); // R8

endmodule

// File: tb/miss_switch_sched_tb.sv
module miss_switch_sched_tb;

    localparam int NV = 23;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        miss_valid;
    logic [1:0]  miss_tid;
    logic        ret_valid;
    logic [1:0]  ret_tid;
    logic        fetch_valid;
    logic [1:0]  fetch_tid;
    logic [15:0] fetch_pc;
    logic [4:0]  squash_mask;
    logic [15:0] cost_total;
    logic [15:0] idle_total;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    miss_switch_sched u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .miss_valid  (miss_valid),
        .miss_tid    (miss_tid),
        .ret_valid   (ret_valid),
        .ret_tid     (ret_tid),
        .fetch_valid (fetch_valid),
        .fetch_tid   (fetch_tid),
        .fetch_pc    (fetch_pc),
        .squash_mask (squash_mask),
        .cost_total  (cost_total),
        .idle_total  (idle_total)
    );

    // row: cyc[39:34] mv[33] mt[32:31] rv[30] rt[29:28] efv[27] etid[26:25] epc[24:9] emask[8:4] req[3:0]
    localparam logic [39:0] VEC [NV] = '{
        {6'd0,  1'b0, 2'd0, 1'b0, 2'd0, 1'b1, 2'd0, 16'h0000, 5'h00, 4'd1},
        {6'd4,  1'b0, 2'd0, 1'b0, 2'd0, 1'b1, 2'd0, 16'h0004, 5'h00, 4'd2},
        {6'd5,  1'b1, 2'd0, 1'b0, 2'd0, 1'b0, 2'd0, 16'h0000, 5'h1F, 4'd4},
        {6'd6,  1'b0, 2'd0, 1'b0, 2'd0, 1'b1, 2'd1, 16'h0100, 5'h00, 4'd6},
        {6'd8,  1'b1, 2'd1, 1'b0, 2'd0, 1'b1, 2'd1, 16'h0102, 5'h00, 4'd3},
        {6'd11, 1'b1, 2'd1, 1'b0, 2'd0, 1'b0, 2'd0, 16'h0000, 5'h1F, 4'd4},
        {6'd12, 1'b0, 2'd0, 1'b0, 2'd0, 1'b1, 2'd2, 16'h0200, 5'h00, 4'd6},
        {6'd17, 1'b1, 2'd0, 1'b1, 2'd0, 1'b1, 2'd2, 16'h0205, 5'h00, 4'd3},
        {6'd18, 1'b1, 2'd2, 1'b0, 2'd0, 1'b0, 2'd0, 16'h0000, 5'h1F, 4'd4},
        {6'd19, 1'b0, 2'd0, 1'b0, 2'd0, 1'b1, 2'd3, 16'h0300, 5'h00, 4'd6},
        {6'd24, 1'b1, 2'd3, 1'b0, 2'd0, 1'b0, 2'd0, 16'h0000, 5'h1F, 4'd4},
        {6'd25, 1'b0, 2'd0, 1'b0, 2'd0, 1'b1, 2'd0, 16'h0000, 5'h00, 4'd5},
        {6'd26, 1'b0, 2'd0, 1'b1, 2'd1, 1'b1, 2'd0, 16'h0001, 5'h00, 4'd8},
        {6'd30, 1'b1, 2'd0, 1'b0, 2'd0, 1'b0, 2'd0, 16'h0000, 5'h1F, 4'd4},
        {6'd31, 1'b0, 2'd0, 1'b0, 2'd0, 1'b1, 2'd1, 16'h0100, 5'h00, 4'd5},
        {6'd36, 1'b1, 2'd1, 1'b0, 2'd0, 1'b0, 2'd0, 16'h0000, 5'h1F, 4'd4},
        {6'd37, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 2'd0, 16'h0000, 5'h00, 4'd7},
        {6'd39, 1'b0, 2'd0, 1'b1, 2'd3, 1'b0, 2'd0, 16'h0000, 5'h00, 4'd7},
        {6'd40, 1'b0, 2'd0, 1'b0, 2'd0, 1'b1, 2'd3, 16'h0300, 5'h00, 4'd8},
        {6'd41, 1'b0, 2'd0, 1'b1, 2'd0, 1'b1, 2'd3, 16'h0301, 5'h00, 4'd2},
        {6'd42, 1'b0, 2'd0, 1'b1, 2'd2, 1'b1, 2'd3, 16'h0302, 5'h00, 4'd2},
        {6'd46, 1'b1, 2'd3, 1'b0, 2'd0, 1'b0, 2'd0, 16'h0000, 5'h1F, 4'd4},
        {6'd47, 1'b0, 2'd0, 1'b0, 2'd0, 1'b1, 2'd0, 16'h0000, 5'h00, 4'd6}
    };

    function automatic string req_name(input logic [3:0] code);
        case (code)
            4'd1:    return "R1";
            4'd2:    return "R2";
            4'd3:    return "R3";
            4'd4:    return "R4";
            4'd5:    return "R5";
            4'd6:    return "R6";
            4'd7:    return "R7";
            4'd8:    return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic mv, input logic [1:0] mt,
                         input logic rv, input logic [1:0] rt);
        miss_valid = mv;
        miss_tid   = mt;
        ret_valid  = rv;
        ret_tid    = rt;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int r;
        rst_n = 1'b0;
        drive(1'b0, 2'd0, 1'b0, 2'd0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1", "fetch_valid", 32'(fetch_valid), 32'd1);
        chk("R1", "cost", 32'(cost_total), 32'd0);
        chk("R1", "idle", 32'(idle_total), 32'd0);

        r = 0;
        for (int c = 0; c < 48; c++) begin
            drive(1'b0, 2'd0, 1'b0, 2'd0);
            if (r < NV && int'(VEC[r][39:34]) == c) begin
                drive(VEC[r][33], VEC[r][32:31], VEC[r][30], VEC[r][29:28]);
                #1;
                chk(req_name(VEC[r][3:0]), "fetch_valid", 32'(fetch_valid), 32'(VEC[r][27]));
                if (VEC[r][27]) begin
                    chk(req_name(VEC[r][3:0]), "fetch_tid", 32'(fetch_tid), 32'(VEC[r][26:25]));
                    chk(req_name(VEC[r][3:0]), "fetch_pc", 32'(fetch_pc), 32'(VEC[r][24:9]));
                end
                chk("R4", "squash_mask", 32'(squash_mask), 32'(VEC[r][8:4]));
                r++;
            end
            @(negedge clk);
        end
        drive(1'b0, 2'd0, 1'b0, 2'd0);
        #1;
        chk("R9", "cost after seven switches", 32'(cost_total), 32'd35);
        chk("R7", "idle cycles", 32'(idle_total), 32'd3);

        // mid-run reset
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        drive(1'b0, 2'd0, 1'b1, 2'd0); // return for a running thread
        #1;
        chk("R1", "tid after reset", 32'(fetch_tid), 32'd0);
        chk("R1", "pc after reset", 32'(fetch_pc), 32'd0);
        chk("R1", "cost after reset", 32'(cost_total), 32'd0);
        chk("R1", "idle after reset", 32'(idle_total), 32'd0);
        @(negedge clk);
        drive(1'b0, 2'd0, 1'b0, 2'd0);
        #1;
        chk("R8", "return to ready thread ignored tid", 32'(fetch_tid), 32'd0);
        chk("R8", "return to ready thread ignored pc", 32'(fetch_pc), 32'd1);
        repeat (4) @(negedge clk);
        drive(1'b1, 2'd0, 1'b0, 2'd0);
        #1;
        chk("R4", "squash in second run", 32'(squash_mask), 32'h1F);
        @(negedge clk);
        drive(1'b0, 2'd0, 1'b0, 2'd0);
        #1;
        chk("R9", "cost after one switch", 32'(cost_total), 32'd5);
        chk("R6", "successor tid", 32'(fetch_tid), 32'd1);
        chk("R6", "successor pc", 32'(fetch_pc), 32'h0100);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule